// File: doc/BRIEF.md
# Autobaud Boot Link Receiver

This block brings up a serial boot link whose speed is not known in advance. After reset it watches the receive line for the sync character 0x40, sent as 8 data bits with one start bit, one stop bit and no parity. It counts how long the line stays low from the start bit to the first one bit. From that count it derives a divisor for a receiver that samples 16 times per bit, and it locks.

Once locked, it answers at the detected rate with a four-byte acknowledgment that carries the divisor back to the host. It then turns into a plain byte receiver that delivers each good character through a valid/ready pair. The clear-to-send output tells the host when it may transmit: during detection, and afterwards only while the consumer is ready.

Top module: `abaud_boot_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, txd is 1, cts is 1, locked is 0, out_valid is 0, frame_err is 0 and divisor is 0.
- R2: The block counts, in clock cycles, how long the synchronized line stays low from the first falling edge until it rises again. If that count L is at least MIN_LOW, locked rises within a few cycles of the rising edge and divisor becomes floor(L / 112), where 112 is 7 low bit times times 16 samples per bit.
- R3: A low period shorter than MIN_LOW clocks (for example 223 clocks when MIN_LOW is 224) leaves locked at 0, and detection restarts on the next falling edge.
- R4: After locking, txd sends exactly four frames back to back: 0xBF, divisor bits 7:0, divisor bits 15:8, then 0x00. Each frame is a 0 start bit, eight data bits LSB first and a 1 stop bit. Every bit lasts divisor*16 clock cycles.
- R5: cts is 1 during detection. It is 0 from lock until the stop bit of the last acknowledgment frame has been sent.
- R6: After the acknowledgment, cts equals out_ready in every cycle.
- R7: In the streaming phase, each received character with a 1 stop bit appears on out_data with out_valid = 1. Bytes arrive in order. out_valid and out_data stay unchanged while out_ready is 0. out_valid is never 1 before lock.
- R8: A received character whose stop bit samples as 0 gives a one-cycle pulse on frame_err. The byte is not delivered and out_data does not change.
- R9: Once set, locked stays 1 and divisor keeps its value until reset, even when another 0x40 arrives. That character is delivered as ordinary data.
- R10: txd is 1 whenever no acknowledgment frame is in progress, both before lock and in the streaming phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| out_ready | input | 1 | Consumer can take a byte |
| txd | output | 1 | Serial transmit line carrying the acknowledgment, idle high |
| cts | output | 1 | 1 when the host may send |
| locked | output | 1 | Rate has been detected |
| divisor | output | DIV_W | Clocks per 1/16 bit, measured from the sync character |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | out_data holds a byte not yet taken |
| frame_err | output | 1 | One-cycle pulse for a character with a bad stop bit |

## Verification
The assertions check on every cycle the properties that hold across the block's phases. Lock is sticky and the divisor is frozen once locked. The divisor is never zero after lock. The transmit line stays idle outside the acknowledgment. No byte is presented before lock. A held byte stays stable while the consumer stalls. A framing error never changes the output byte. Only the bench's scenarios can show that the divisor actually equals the measured low time over 112 and that the rejection threshold sits exactly at MIN_LOW. The same goes for the content and bit timing of the four acknowledgment frames, the cts hand-over from the acknowledgment to the streaming phase, and byte order and discarding under a mix of good and bad stop bits.

// File: rtl/abaud_pkg.sv
package abaud_pkg;

    localparam int SYNC_LOW_BITS = 7;
    localparam int OVERSAMPLE    = 16;
    localparam int LOW_SCALE     = SYNC_LOW_BITS * OVERSAMPLE;

    localparam logic [7:0] ACK_HEAD = 8'hBF;
    localparam logic [7:0] ACK_TAIL = 8'h00;

    typedef enum logic [1:0] {
        PH_DETECT,
        PH_ACK,
        PH_STREAM
    } phase_e;

    typedef enum logic [1:0] {
        M_ARM,
        M_IDLE,
        M_COUNT
    } meas_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_e;

    typedef struct packed {
        logic [9:0] bits;
        logic [3:0] pos;
        logic [1:0] idx;
    } tx_frame_s;

    function automatic logic [7:0] ack_byte(input logic [1:0] idx, input logic [15:0] d);
        case (idx)
            2'd0:    return ACK_HEAD;
            2'd1:    return d[7:0];
            2'd2:    return d[15:8];
            default: return ACK_TAIL;
        endcase
    endfunction

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/abaud_tick.sv
module abaud_tick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] period,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = !clr && (cnt_q == period - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/abaud_measure.sv
module abaud_measure
    import abaud_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int CNT_W   = DIV_W + 7,
    parameter int MIN_LOW = 224
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    output logic             found,
    output logic [DIV_W-1:0] div_val
);
    meas_e            st_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        found   = en && (st_q == M_COUNT) && line && (cnt_q >= CNT_W'(MIN_LOW));
        div_val = DIV_W'(cnt_q / CNT_W'(LOW_SCALE));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q  <= M_ARM;
            cnt_q <= '0;
        end else begin
            case (st_q)
                M_ARM: begin
                    if (line) st_q <= M_IDLE;
                end
                M_IDLE: begin
                    if (!line) begin
                        st_q  <= M_COUNT;
                        cnt_q <= CNT_W'(1);
                    end
                end
                M_COUNT: begin
                    if (line) begin
                        st_q <= M_IDLE;
                    end else if (cnt_q != '1) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= M_ARM;
            endcase
        end
    end
endmodule

// File: rtl/abaud_tx.sv
module abaud_tx
    import abaud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    output logic             txd,
    output logic             done
);
    localparam int BW = DIV_W + 4;

    logic [BW-1:0] bit_len;
    logic [BW-1:0] timer_q;
    logic [15:0]   div16;
    tx_frame_s     fr_q;
    logic          busy_q;

    assign bit_len = {div, 4'b0000};
    assign div16   = 16'(div);
    assign txd     = busy_q ? fr_q.bits[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done    <= 1'b0;
            timer_q <= '0;
            fr_q    <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy_q    <= 1'b1;
                timer_q   <= '0;
                fr_q.idx  <= 2'd0;
                fr_q.pos  <= 4'd0;
                fr_q.bits <= frame_of(ack_byte(2'd0, div16));
            end else if (busy_q) begin
                if (timer_q == bit_len - BW'(1)) begin
                    timer_q <= '0;
                    if (fr_q.pos == 4'd9) begin
                        if (fr_q.idx == 2'd3) begin
                            busy_q <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            fr_q.idx  <= fr_q.idx + 2'd1;
                            fr_q.pos  <= 4'd0;
                            fr_q.bits <= frame_of(ack_byte(fr_q.idx + 2'd1, div16));
                        end
                    end else begin
                        fr_q.pos  <= fr_q.pos + 4'd1;
                        fr_q.bits <= {1'b1, fr_q.bits[9:1]};
                    end
                end else begin
                    timer_q <= timer_q + BW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/abaud_rx.sv
module abaud_rx
    import abaud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    input  logic [DIV_W-1:0] div,
    input  logic             ready,
    output logic [7:0]       data,
    output logic             valid,
    output logic             ferr
);
    rx_e        st_q;
    logic [3:0] sub_q;
    logic [2:0] nbit_q;
    logic [7:0] sh_q;
    logic       prev_q;
    logic       tick;

    abaud_tick #(.W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr    (st_q == RX_IDLE),
        .period (div),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q   <= RX_IDLE;
            sub_q  <= '0;
            nbit_q <= '0;
            sh_q   <= '0;
            prev_q <= 1'b1;
            data   <= '0;
            valid  <= 1'b0;
            ferr   <= 1'b0;
        end else begin
            prev_q <= line;
            ferr   <= 1'b0;
            if (valid && ready) valid <= 1'b0;
            case (st_q)
                RX_IDLE: begin
                    if (prev_q && !line) begin
                        st_q  <= RX_START;
                        sub_q <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (sub_q == 4'd7) begin
                            sub_q  <= '0;
                            nbit_q <= '0;
                            st_q   <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            sub_q <= sub_q + 4'd1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (sub_q == 4'd15) begin
                            sub_q <= '0;
                            sh_q  <= {line, sh_q[7:1]};
                            if (nbit_q == 3'd7) st_q <= RX_STOP;
                            else nbit_q <= nbit_q + 3'd1;
                        end else begin
                            sub_q <= sub_q + 4'd1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (sub_q == 4'd15) begin
                            st_q <= RX_IDLE;
                            if (line) begin
                                if (!valid || ready) begin
                                    valid <= 1'b1;
                                    data  <= sh_q;
                                end
                            end else begin
                                ferr <= 1'b1;
                            end
                        end else begin
                            sub_q <= sub_q + 4'd1;
                        end
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/abaud_boot_rx.sv
module abaud_boot_rx
    import abaud_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int MIN_LOW     = 224,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic             out_ready,
    output logic             txd,
    output logic             cts,
    output logic             locked,
    output logic [DIV_W-1:0] divisor,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             frame_err
);
    localparam int CNT_W = DIV_W + $clog2(LOW_SCALE);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_s;
    phase_e                 phase_q;
    logic [DIV_W-1:0]       div_q;
    logic                   go_q;
    logic                   found;
    logic [DIV_W-1:0]       meas_div;
    logic                   tx_done;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else if (g == 0) sync_q[g] <= rxd;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign rxd_s = sync_q[SYNC_STAGES-1];

    abaud_measure #(
        .DIV_W   (DIV_W),
        .CNT_W   (CNT_W),
        .MIN_LOW (MIN_LOW)
    ) u_measure (
        .clk     (clk),
        .rst     (rst),
        .en      (phase_q == PH_DETECT),
        .line    (rxd_s),
        .found   (found),
        .div_val (meas_div)
    );

    abaud_tx #(.DIV_W(DIV_W)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .go   (go_q),
        .div  (div_q),
        .txd  (txd),
        .done (tx_done)
    );

    abaud_rx #(.DIV_W(DIV_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .en    (phase_q == PH_STREAM),
        .line  (rxd_s),
        .div   (div_q),
        .ready (out_ready),
        .data  (out_data),
        .valid (out_valid),
        .ferr  (frame_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DETECT;
            div_q   <= '0;
            go_q    <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (phase_q)
                PH_DETECT: begin
                    if (found) begin
                        div_q   <= meas_div;
                        phase_q <= PH_ACK;
                        go_q    <= 1'b1;
                    end
                end
                PH_ACK: begin
                    if (tx_done) phase_q <= PH_STREAM;
                end
                default: phase_q <= PH_STREAM;
            endcase
        end
    end

    assign locked  = (phase_q != PH_DETECT);
    assign divisor = div_q;
    assign cts     = (phase_q == PH_DETECT) || ((phase_q == PH_STREAM) && out_ready);

endmodule

// File: rtl/abaud_boot_rx_chk.sv
module abaud_boot_rx_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             txd,
    input logic             locked,
    input logic             out_ready,
    input logic             out_valid,
    input logic             frame_err,
    input logic [DIV_W-1:0] divisor,
    input logic [7:0]       out_data,
    input abaud_pkg::phase_e phase_q
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R9

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(divisor)); // R9

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        locked |-> (divisor != '0)); // R2

    AST_TXD_IDLE_DETECT: assert property (@(posedge clk) disable iff (rst)
        !locked |-> txd); // R10

    AST_TXD_IDLE_STREAM: assert property (@(posedge clk) disable iff (rst)
        (phase_q == abaud_pkg::PH_STREAM) |-> txd); // R10

    AST_NO_BYTE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !locked |-> !out_valid); // R7

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

    AST_FERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $stable(out_data)); // R8
endmodule

bind abaud_boot_rx abaud_boot_rx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .txd       (txd),
    .locked    (locked),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .frame_err (frame_err),
    .divisor   (divisor),
    .out_data  (out_data),
    .phase_q   (phase_q)
);

// File: tb/abaud_boot_rx_test.sv
module abaud_boot_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;
    localparam int MIN_LOW    = 224;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rxd = 1'b1;
    logic             out_ready = 1'b0;
    logic             txd, cts, locked, out_valid, frame_err;
    logic [DIV_W-1:0] divisor;
    logic [7:0]       out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    bit         model_locked = 0;
    bit         lock_dc = 0;
    int         model_phase = 0;   // 0 detect, 1 ack, 2 stream, 3 transition
    int         exp_div = 0;
    logic [7:0] exp_q[$];
    int         ferr_seen = 0;
    int         ferr_exp = 0;
    bit         ready_hold = 0;
    int         cyc = 0;
    bit         prev_valid = 0;
    bit         prev_ready = 0;
    logic [7:0] prev_data = '0;

    abaud_boot_rx #(.DIV_W(DIV_W), .MIN_LOW(MIN_LOW), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst       (rst),
        .rxd       (rxd),
        .out_ready (out_ready),
        .txd       (txd),
        .cts       (cts),
        .locked    (locked),
        .divisor   (divisor),
        .out_data  (out_data),
        .out_valid (out_valid),
        .frame_err (frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // consumer readiness pattern
    always @(negedge clk) begin
        cyc <= cyc + 1;
        out_ready <= !ready_hold && ((cyc % 200) >= 40);
    end

    // per-clock comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            if (!lock_dc) begin
                chk(locked == model_locked, "R2/R3 locked", locked, model_locked);
                if (model_locked)
                    chk(divisor == DIV_W'(exp_div), "R9 divisor", divisor, exp_div);
            end
            if (model_phase == 0 && !lock_dc) begin
                chk(cts == 1'b1, "R5 cts in detect", cts, 1);
                chk(txd == 1'b1, "R10 txd idle in detect", txd, 1);
            end
            if (model_phase == 1)
                chk(cts == 1'b0, "R5 cts during ack", cts, 0);
            if (model_phase == 2) begin
                chk(cts == out_ready, "R6 cts follows ready", cts, out_ready);
                chk(txd == 1'b1, "R10 txd idle in stream", txd, 1);
            end
            if (prev_valid && !prev_ready) begin
                chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
                chk(out_data == prev_data, "R7 data held", out_data, prev_data);
            end
            if (!model_locked && !lock_dc)
                chk(out_valid == 1'b0, "R7 no byte before lock", out_valid, 0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R7 byte order/value", out_data, e);
                end
            end
            if (frame_err) ferr_seen++;
            prev_valid = out_valid;
            prev_ready = out_ready;
            prev_data  = out_data;
        end else begin
            prev_valid = 0;
            prev_ready = 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sync character 0x40: 7 low bit times, one high, one low, stop
    task automatic send_sync(input int bit_clk);
        exp_div = (7 * bit_clk) / 112;
        rxd = 1'b0;
        wait_clk(7 * bit_clk);
        rxd = 1'b1;
        lock_dc = 1;
        wait_clk(5);
        model_locked = 1;
        model_phase  = 1;
        lock_dc = 0;
        wait_clk(bit_clk - 5);
        rxd = 1'b0;
        wait_clk(bit_clk);
        rxd = 1'b1;
        wait_clk(bit_clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop, input int bit_clk);
        if (stop) exp_q.push_back(b);
        else ferr_exp++;
        rxd = 1'b0;
        wait_clk(bit_clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clk(bit_clk);
        end
        rxd = stop;
        wait_clk(bit_clk);
        rxd = 1'b1;
        wait_clk(2 * bit_clk);
    endtask

    // decode the four acknowledgment frames on txd (R4)
    task automatic mon_ack(input int bit_clk);
        logic [7:0] exp_b [4];
        logic [7:0] got;
        wait (model_locked == 1);
        exp_b[0] = 8'hBF;
        exp_b[1] = exp_div[7:0];
        exp_b[2] = exp_div[15:8];
        exp_b[3] = 8'h00;
        for (int k = 0; k < 4; k++) begin
            do begin
                @(negedge clk);
                #1;
            end while (txd !== 1'b0);
            wait_clk(bit_clk / 2);
            #1;
            chk(txd == 1'b0, "R4 ack start bit", txd, 0);
            for (int i = 0; i < 8; i++) begin
                wait_clk(bit_clk);
                #1;
                got[i] = txd;
            end
            chk(got == exp_b[k], "R4 ack byte", got, exp_b[k]);
            wait_clk(bit_clk);
            #1;
            chk(txd == 1'b1, "R4 ack stop bit", txd, 1);
        end
        model_phase = 3;
        wait_clk(bit_clk / 2 + 4);
        model_phase = 2;
    endtask

    task automatic reset_checks();
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(cts == 1'b1, "R1 cts", cts, 1);
        chk(locked == 1'b0, "R1 locked", locked, 0);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        chk(divisor == '0, "R1 divisor", divisor, 0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        rxd = 1'b1;
        model_locked = 0;
        model_phase  = 0;
        lock_dc      = 0;
        exp_div      = 0;
        exp_q.delete();
        ferr_seen = 0;
        ferr_exp  = 0;
        wait_clk(5);
        #1;
        reset_checks();
        @(negedge clk);
        rst = 1'b0;
        #1;
        reset_checks();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "watchdog R7 run incomplete", 0, 1);
        finish_run();
    end

    initial begin
        // run 1: bit time 80 clocks, divisor 5
        apply_reset();
        wait_clk(50);
        fork
            send_sync(80);
            mon_ack(80);
        join
        chk(divisor == 16'd5, "R2 divisor from 560 low clocks", divisor, 5);
        wait_clk(100);
        send_byte(8'h5A, 1'b1, 80);
        send_byte(8'h00, 1'b1, 80);
        // R7 stall: consumer not ready, byte must wait, cts low (R6)
        ready_hold = 1;
        send_byte(8'hA5, 1'b1, 80);
        #1;
        chk(out_valid == 1'b1, "R7 byte waits while stalled", out_valid, 1);
        chk(out_data == 8'hA5, "R7 held byte value", out_data, 8'hA5);
        chk(cts == 1'b0, "R6 cts low while stalled", cts, 0);
        ready_hold = 0;
        wait_clk(20);
        // R8: bad stop bit dropped
        send_byte(8'h33, 1'b0, 80);
        send_byte(8'hFF, 1'b1, 80);
        // R9: a second sync character is plain data
        send_byte(8'h40, 1'b1, 80);
        send_byte(8'h7E, 1'b1, 80);
        wait_clk(300);
        chk(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
        chk(ferr_seen == ferr_exp, "R8 framing pulses", ferr_seen, ferr_exp);
        chk(divisor == 16'd5 && locked, "R9 divisor kept", divisor, 5);

        // run 2: threshold boundary, bit time 32 clocks, divisor 2
        apply_reset();
        wait_clk(20);
        rxd = 1'b0;
        wait_clk(MIN_LOW - 1);
        rxd = 1'b1;
        wait_clk(300);
        chk(locked == 1'b0, "R3 short low rejected", locked, 0);
        fork
            send_sync(32);
            mon_ack(32);
        join
        chk(divisor == 16'd2, "R2 divisor at MIN_LOW", divisor, 2);
        wait_clk(50);
        send_byte(8'hC3, 1'b1, 32);
        send_byte(8'h81, 1'b0, 32);
        send_byte(8'h18, 1'b1, 32);
        wait_clk(300);
        chk(exp_q.size() == 0, "R7 run 2 bytes delivered", exp_q.size(), 0);
        chk(ferr_seen == ferr_exp, "R8 run 2 framing pulses", ferr_seen, ferr_exp);
        finish_run();
    end
endmodule